// File: doc/BRIEF.md
# Sliced VBI Ancillary Packet Parser

This block watches a byte-wide stream of video ancillary data, one byte per clock when the valid strobe is high. It picks out packets that carry sliced vertical-blanking services. Line-boundary timing codes and idle filler can come before a packet, and the parser skips them while it hunts for the three-byte packet preamble. When a preamble is found, the parser reads these bytes in order:

- the data identifier, which also tells which field the packet belongs to;
- the secondary identifier, which holds the service code;
- the word count;
- two internal identifier bytes, the first of which holds the line number.

It then passes the payload bytes through on a separate strobed byte output.

After the last payload byte of a packet, the parser emits one result record in a single-cycle pulse. The record holds the service code, the corrected line number (the line number plus a programmable offset), the second-field flag and an error flag. The parser checks caption parity on the first two payload bytes. It does not check packet checksums and does not decode biphase payloads. All outputs are registered, so each one follows the input byte that caused it by one cycle.

Top module: `vbi_anc_parser`

## Requirements
- R1: A packet starts only after the bytes 0x00, 0xFF, 0xFF arrive in a row. A 0x00 that breaks a partial match starts a new match, so 0x00 0x00 0xFF 0xFF and 0x00 0xFF 0x00 0xFF 0xFF are both accepted. A partial match that fails produces no output.
- R2: Timing codes (0xFF 0x00 0x00 then a status byte other than 0xFF) and any number of idle bytes before the preamble are skipped.
- R3: The byte after the preamble must be 0x91 (first field, `res_field2_o`=0) or 0x55 (second field, `res_field2_o`=1). Any other value ends the packet with a result that has `res_err_o`=1. That result arrives one cycle after the rejected byte, and no payload is passed for that packet.
- R4: The service code is bits [3:0] of the secondary identifier byte. The codes 1, 4, 6 and 9 are valid, and any other code makes the packet an error.
- R5: For an error-free packet, `res_line_o` equals bits [LINE_W-1:0] of the first internal identifier byte plus `line_offset_i`, with no wraparound.
- R6: For service code 6 (caption), the packet is an error if either of the first two payload bytes has even parity, or if the word count is zero.
- R7: The payload length is 4 times bits [5:0] of the word-count byte. Each payload byte appears on `pay_data_o` with `pay_valid_o` high one cycle after it is accepted, in the order it arrived.
- R8: When `res_err_o` is 1, `res_type_o`, `res_line_o` and `res_field2_o` are all 0.
- R9: `res_valid_o` is a one-cycle pulse. It comes one cycle after the last payload byte, or one cycle after the second internal identifier byte when the word count is zero. The parser then goes back to looking for a preamble.
- R10: A cycle with `valid_i` low changes no state and produces no `pay_valid_o` or `res_valid_o` in the following cycle.
- R11: While `rst_ni` is low, all outputs are zero and the parser is looking for a preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input byte strobe |
| byte_i | input | 8 | Input stream byte |
| line_offset_i | input | LINE_W | Amount added to the line number field |
| res_valid_o | output | 1 | One-cycle result pulse |
| res_err_o | output | 1 | Packet error flag |
| res_type_o | output | 4 | Service code (0 when the packet is in error) |
| res_line_o | output | LINE_W+1 | Corrected line number (0 when the packet is in error) |
| res_field2_o | output | 1 | Packet belongs to the second field |
| pay_valid_o | output | 1 | Payload byte strobe |
| pay_data_o | output | 8 | Payload byte |

## Verification
The bound assertions check these rules on every cycle:
- an error result carries all-zero fields;
- the result strobe never lasts more than one cycle;
- a clean result always names one of the four valid services;
- a stalled input cycle never produces output;
- reset holds the outputs at zero.

Other behaviours can only be shown by the bench's scenarios against its own model of the expected values. These are preamble resynchronisation, skipping of timing codes and idle bytes, the rejection of identifiers, the caption parity rules, the line-offset arithmetic, the payload length and order, and the exact cycle of the result pulse.

// File: rtl/vbi_anc_pkg.sv
package vbi_anc_pkg;
  localparam int BYTE_W = 8;
  localparam int SVC_W  = 4;

  typedef enum logic [2:0] {
    S_SCAN, S_DID, S_SDID, S_WC, S_ID0, S_ID1, S_PAY
  } pstate_e;

  localparam logic [BYTE_W-1:0] PRE_LO = 8'h00;
  localparam logic [BYTE_W-1:0] PRE_HI = 8'hFF;
  localparam logic [BYTE_W-1:0] DID_F1 = 8'h91;
  localparam logic [BYTE_W-1:0] DID_F2 = 8'h55;

  localparam logic [SVC_W-1:0] SVC_TTX = 4'd1;
  localparam logic [SVC_W-1:0] SVC_WSS = 4'd4;
  localparam logic [SVC_W-1:0] SVC_CC  = 4'd6;
  localparam logic [SVC_W-1:0] SVC_VPS = 4'd9;

  function automatic logic odd_par(input logic [BYTE_W-1:0] b);
    return ^b;
  endfunction
endpackage

// File: rtl/vbi_pre_match.sv
module vbi_pre_match
  import vbi_anc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              hit_o
);
  // cnt_q: number of preamble bytes matched so far
  logic [1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    hit_o = 1'b0;
    if (en_i) begin
      if (byte_i == PRE_LO) begin
        cnt_d = 2'd1;  // a low byte always restarts the match
      end else if (byte_i == PRE_HI && cnt_q == 2'd1) begin
        cnt_d = 2'd2;
      end else if (byte_i == PRE_HI && cnt_q == 2'd2) begin
        cnt_d = 2'd0;
        hit_o = 1'b1;
      end else begin
        cnt_d = 2'd0;
      end
    end
    if (clr_i) cnt_d = 2'd0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= 2'd0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/vbi_pay_cnt.sv
module vbi_pay_cnt #(
  parameter int WC_W  = 6,
  parameter int CNT_W = WC_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WC_W-1:0]  wc_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             zero_o,
  output logic             last_o
);
  logic [CNT_W-1:0] total_q, idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_q <= '0;
      idx_q   <= '0;
    end else if (load_i) begin
      total_q <= {wc_i, 2'b00};  // dwords to bytes
      idx_q   <= '0;
    end else if (step_i) begin
      idx_q   <= idx_q + 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign zero_o = (total_q == '0);
  assign last_o = (idx_q == total_q - 1'b1);
endmodule

// File: rtl/vbi_svc_check.sv
module vbi_svc_check
  import vbi_anc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              pay_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [SVC_W-1:0]  svc_i,
  input  logic              wc_zero_i,
  output logic              err_o
);
  logic bad_q, bad_now, chk, known, is_cc;

  assign chk     = pay_i && (idx_i < CNT_W'(2)) && !odd_par(byte_i);
  assign bad_now = bad_q | chk;
  assign known   = (svc_i == SVC_TTX) || (svc_i == SVC_WSS) ||
                   (svc_i == SVC_CC)  || (svc_i == SVC_VPS);
  assign is_cc   = (svc_i == SVC_CC);
  assign err_o   = !known || (is_cc && (wc_zero_i || bad_now));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bad_q <= 1'b0;
    else if (clr_i) bad_q <= 1'b0;
    else if (chk)   bad_q <= 1'b1;
  end
endmodule

// File: rtl/vbi_anc_parser.sv
module vbi_anc_parser
  import vbi_anc_pkg::*;
#(
  parameter int LINE_W = 6,
  parameter int WC_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [LINE_W-1:0] line_offset_i,
  output logic              res_valid_o,
  output logic              res_err_o,
  output logic [SVC_W-1:0]  res_type_o,
  output logic [LINE_W:0]   res_line_o,
  output logic              res_field2_o,
  output logic              pay_valid_o,
  output logic [BYTE_W-1:0] pay_data_o
);
  localparam int CNT_W = WC_W + 2;

  pstate_e st_q, st_d;
  logic f2_q;
  logic [SVC_W-1:0] svc_q;
  logic [LINE_W-1:0] lid_q;

  logic hit, did_ok, load, step, emit, reject, svc_err, zero, last;
  logic [CNT_W-1:0] idx;
  logic [LINE_W:0] line_sum;

  assign did_ok = (byte_i == DID_F1) || (byte_i == DID_F2);
  assign load   = valid_i && (st_q == S_WC);
  assign step   = valid_i && (st_q == S_PAY);
  assign emit   = valid_i && (((st_q == S_ID1) && zero) || ((st_q == S_PAY) && last));
  assign reject = valid_i && (st_q == S_DID) && !did_ok;
  assign line_sum = {1'b0, lid_q} + {1'b0, line_offset_i};

  vbi_pre_match u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_q != S_SCAN),
    .en_i   (valid_i && (st_q == S_SCAN)),
    .byte_i (byte_i),
    .hit_o  (hit)
  );

  vbi_pay_cnt #(.WC_W(WC_W), .CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .wc_i   (byte_i[WC_W-1:0]),
    .step_i (step),
    .idx_o  (idx),
    .zero_o (zero),
    .last_o (last)
  );

  vbi_svc_check #(.CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (load),
    .pay_i     (step),
    .idx_i     (idx),
    .byte_i    (byte_i),
    .svc_i     (svc_q),
    .wc_zero_i (zero),
    .err_o     (svc_err)
  );

  always_comb begin
    st_d = st_q;
    if (valid_i) begin
      unique case (st_q)
        S_SCAN: if (hit) st_d = S_DID;
        S_DID:  st_d = did_ok ? S_SDID : S_SCAN;
        S_SDID: st_d = S_WC;
        S_WC:   st_d = S_ID0;
        S_ID0:  st_d = S_ID1;
        S_ID1:  st_d = zero ? S_SCAN : S_PAY;
        S_PAY:  if (last) st_d = S_SCAN;
        default: st_d = S_SCAN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_SCAN;
      f2_q  <= 1'b0;
      svc_q <= '0;
      lid_q <= '0;
    end else begin
      st_q <= st_d;
      if (valid_i && st_q == S_DID && did_ok) f2_q  <= (byte_i == DID_F2);
      if (valid_i && st_q == S_SDID)          svc_q <= byte_i[SVC_W-1:0];
      if (valid_i && st_q == S_ID0)           lid_q <= byte_i[LINE_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_err_o    <= 1'b0;
      res_type_o   <= '0;
      res_line_o   <= '0;
      res_field2_o <= 1'b0;
      pay_valid_o  <= 1'b0;
      pay_data_o   <= '0;
    end else begin
      res_valid_o <= emit || reject;
      pay_valid_o <= step;
      if (step) pay_data_o <= byte_i;
      if (reject) begin
        res_err_o    <= 1'b1;
        res_type_o   <= '0;
        res_line_o   <= '0;
        res_field2_o <= 1'b0;
      end else if (emit) begin
        res_err_o    <= svc_err;
        res_type_o   <= svc_err ? '0 : svc_q;
        res_line_o   <= svc_err ? '0 : line_sum;
        res_field2_o <= svc_err ? 1'b0 : f2_q;
      end
    end
  end
endmodule

// File: rtl/vbi_anc_parser_chk.sv
module vbi_anc_parser_chk
  import vbi_anc_pkg::*;
#(
  parameter int LINE_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             res_valid_o,
  input logic             res_err_o,
  input logic [SVC_W-1:0] res_type_o,
  input logic [LINE_W:0]  res_line_o,
  input logic             res_field2_o,
  input logic             pay_valid_o
);
  assert_err_zeroes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_err_o) |-> (res_type_o == '0 && res_line_o == '0 && !res_field2_o));

  assert_res_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  assert_clean_svc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_err_o) |-> (res_type_o == SVC_TTX || res_type_o == SVC_WSS ||
                                     res_type_o == SVC_CC  || res_type_o == SVC_VPS));

  assert_stall_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!pay_valid_o && !res_valid_o));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R11: assert (!res_valid_o && !pay_valid_o && !res_err_o &&
                                      res_type_o == '0 && res_line_o == '0);
    end
  end
endmodule

bind vbi_anc_parser vbi_anc_parser_chk #(.LINE_W(LINE_W)) u_chk_bind (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .res_valid_o  (res_valid_o),
  .res_err_o    (res_err_o),
  .res_type_o   (res_type_o),
  .res_line_o   (res_line_o),
  .res_field2_o (res_field2_o),
  .pay_valid_o  (pay_valid_o)
);

// File: tb/vbi_anc_parser_tb.sv
`timescale 1ns/1ps
module vbi_anc_parser_tb;
  localparam int LINE_W = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [7:0] din = 8'h00;
  logic [LINE_W-1:0] ofs = '0;
  logic res_valid, res_err, res_f2, pay_valid;
  logic [3:0] res_type;
  logic [LINE_W:0] res_line;
  logic [7:0] pay_data;

  vbi_anc_parser #(.LINE_W(LINE_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .byte_i(din),
    .line_offset_i(ofs), .res_valid_o(res_valid), .res_err_o(res_err),
    .res_type_o(res_type), .res_line_o(res_line), .res_field2_o(res_f2),
    .pay_valid_o(pay_valid), .pay_data_o(pay_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [12:0] exp_res_q[$];
  string       exp_tag_q[$];
  logic [7:0]  exp_pay_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare results and payload in arrival order
  always @(negedge clk) begin
    if (rst_n) begin
      if (pay_valid) begin
        if (exp_pay_q.size() == 0) check(1'b0, "R7 unexpected payload byte", pay_data, 0);
        else begin
          automatic logic [7:0] e = exp_pay_q.pop_front();
          check(pay_data == e, "R7 payload byte", pay_data, e);
        end
      end
      if (res_valid) begin
        automatic logic [12:0] act = {res_err, res_type, res_line, res_f2};
        if (exp_res_q.size() == 0) check(1'b0, "R1 unexpected result", act, 0);
        else begin
          automatic logic [12:0] e = exp_res_q.pop_front();
          automatic string t = exp_tag_q.pop_front();
          check(act == e, t, act, e);
        end
      end
    end
  end

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    din = b;
    valid = 1'b1;
  endtask

  task automatic stall(input int n);
    repeat (n) begin
      @(negedge clk);
      valid = 1'b0;
      din = 8'h00;  // junk byte: must be ignored
    end
  endtask

  task automatic finish_pkt();
    @(negedge clk);
    valid = 1'b0;
    check(res_valid == 1'b1, "R9 result pulse after last byte", res_valid, 1);
    @(negedge clk);
    check(res_valid == 1'b0, "R9 result pulse is one cycle", res_valid, 0);
  endtask

  task automatic send_pkt(input logic [7:0] did, input logic [7:0] sdid,
                          input logic [7:0] wc, input logic [7:0] id0,
                          input logic [7:0] p0, input logic [7:0] p1,
                          input string tag, input bit eav, input int n_idle,
                          input int gap);
    bit err;
    int n;
    logic [3:0] svc;
    logic [LINE_W:0] ln;
    if (eav) begin put(8'hFF); put(8'h00); put(8'h00); put(8'hB0); end
    repeat (n_idle) put(8'h10);
    put(8'h00); put(8'hFF); put(8'hFF);
    put(did);
    if (did != 8'h91 && did != 8'h55) begin
      exp_res_q.push_back(13'h1000);
      exp_tag_q.push_back({tag, " R3 rejected identifier"});
      finish_pkt();
      return;
    end
    svc = sdid[3:0];
    n = int'(wc[5:0]) * 4;
    err = !(svc == 4'd1 || svc == 4'd4 || svc == 4'd6 || svc == 4'd9) ||
          (svc == 4'd6 && (n == 0 || !(^p0) || !(^p1)));
    ln = {1'b0, id0[LINE_W-1:0]} + {1'b0, ofs};
    exp_res_q.push_back(err ? 13'h1000 : {1'b0, svc, ln, did == 8'h55});
    exp_tag_q.push_back(tag);
    stall(gap); put(sdid);
    stall(gap); put(wc);
    stall(gap); put(id0);
    stall(gap); put(8'h80);
    for (int k = 0; k < n; k++) begin
      automatic logic [7:0] b = (k == 0) ? p0 : (k == 1) ? p1 : 8'(k * 29 + 7);
      exp_pay_q.push_back(b);
      stall(gap);
      put(b);
    end
    finish_pkt();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(res_valid == 0 && pay_valid == 0 && res_err == 0, "R11 reset outputs", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    send_pkt(8'h91, 8'hC1, 8'h02, 8'h0A, 8'h11, 8'h22, "R4 teletext field1", 0, 0, 0);
    ofs = 6'd5;
    send_pkt(8'h55, 8'h44, 8'h01, 8'h57, 8'h33, 8'h44, "R2 WSS after timing code and idle", 1, 3, 0);
    ofs = 6'd63;
    send_pkt(8'h91, 8'h06, 8'h01, 8'h3F, 8'h80, 8'h01, "R5 caption max line offset", 1, 0, 0);
    ofs = 6'd2;
    send_pkt(8'h55, 8'h06, 8'h01, 8'h15, 8'h80, 8'h03, "R6 caption even parity", 0, 2, 0);
    send_pkt(8'h91, 8'h06, 8'h00, 8'h15, 8'h80, 8'h01, "R6 caption zero count", 0, 0, 0);
    send_pkt(8'h55, 8'h09, 8'h03, 8'h10, 8'h5A, 8'hA5, "R7 VPS twelve bytes", 0, 0, 0);
    send_pkt(8'h91, 8'h02, 8'h01, 8'h10, 8'h01, 8'h02, "R8 unknown service", 0, 0, 0);
    send_pkt(8'h92, 8'h01, 8'h01, 8'h10, 8'h01, 8'h02, "R3 bad did", 0, 0, 0);

    put(8'h00);  // stream 00 00 FF FF
    send_pkt(8'h91, 8'h01, 8'h01, 8'h08, 8'h01, 8'h02, "R1 double low restart", 0, 0, 0);
    put(8'h00); put(8'hFF);  // stream 00 FF 00 FF FF
    send_pkt(8'h55, 8'h04, 8'h01, 8'h09, 8'h01, 8'h02, "R1 broken match restart", 0, 0, 0);
    put(8'h00); put(8'hFF); put(8'h12); put(8'hFF);  // failed matches
    stall(3);
    check(res_valid == 0, "R1 failed match gives nothing", res_valid, 0);

    send_pkt(8'h91, 8'h06, 8'h01, 8'h0C, 8'h80, 8'h01, "R10 stalls inside packet", 0, 0, 2);

    // reset mid-packet
    put(8'h00); put(8'hFF); put(8'hFF); put(8'h91); put(8'h01);
    @(negedge clk);
    valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(res_type == 0 && res_line == 0 && !res_f2 && !pay_valid, "R11 reset clears outputs",
          {res_type, res_line}, 0);
    rst_n = 1'b1;
    ofs = 6'd0;
    send_pkt(8'h55, 8'h01, 8'h01, 8'h07, 8'h01, 8'h02, "R11 parse after reset", 0, 0, 0);

    stall(4);
    check(exp_res_q.size() == 0, "R9 all results seen", exp_res_q.size(), 0);
    check(exp_pay_q.size() == 0, "R7 all payload seen", exp_pay_q.size(), 0);
    summary();
    $finish;
  end
endmodule